// File: doc/BRIEF.md
# Command Slot Issue Scanner

This block sits in front of the command engine of one storage port and decides which issued command slot runs next. Software sets bits in a slot-issue vector; each set bit marks a slot holding a command ready to run. When a rescan is requested and the port is running, the scanner walks the vector from the lowest slot upward and offers one slot index at a time to the engine over a valid/acknowledge pair.

The engine reports its outcome through its two status bits, busy and data-request, sampled on the acknowledge cycle. If both are low, the command finished on the spot and the slot's issue bit is cleared at once. If either is high, the command is still running. Its slot number is then held as the single outstanding busy slot and its issue bit stays set. When both status bits later drop, that slot's bit is cleared, the record is emptied and a new pass starts from slot 0. A port reset throws away the busy record and any scan in progress, pending or active.

Top module: `cmd_slot_scanner`

## Requirements
- R1: After `rst`, `disp_valid` is 0 and `issue_vec` is all zeros.
- R2: A pulse on `issue_we` ORs `issue_wdata` into `issue_vec`, where bit i stands for slot i. Zero bits in the data clear nothing. The write also requests a scan.
- R3: A pending scan request is consumed when the scanner is idle. It starts a pass only if `run_en` is 1 and `issue_vec` is non-zero at that moment; otherwise it is dropped and no slot is offered until a new request arrives.
- R4: Within a pass, slots are offered in ascending index order on `disp_slot` (a binary slot number), and only slots whose issue bit is set are offered. At most one offer is outstanding. `disp_valid` and `disp_slot` hold steady until `disp_ack`, unless the engine turns busy. The pass ends after the highest issued slot.
- R5: `disp_ack` while `eng_bsy` and `eng_drq` are both 0 clears the offered slot's bit in `issue_vec` on that clock edge.
- R6: The engine counts as busy when `eng_bsy` or `eng_drq` is 1. A busy engine is never offered a new slot. An offer that sees the engine busy without `disp_ack` is withdrawn on the next edge and its bit stays set. Either case ends the pass.
- R7: `disp_ack` while the engine is busy keeps the slot's issue bit set and records that slot as the outstanding busy slot.
- R8: When a busy slot is recorded and both `eng_bsy` and `eng_drq` are 0, that slot's issue bit is cleared, the record is emptied, and a new pass starts from slot 0.
- R9: A pulse on `cmd_we` (a command-register write) requests a scan exactly as an issue write does.
- R10: `port_rst` withdraws any offer, cancels a pass and any pending request, and empties the busy record. The recorded slot's issue bit is then never cleared by the engine going idle. `issue_vec` itself is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| port_rst | input | 1 | Port reset: cancels scanning and empties the busy record |
| run_en | input | 1 | Port start bit; scanning is allowed only while set |
| issue_we | input | 1 | Write strobe for the slot-issue vector |
| issue_wdata | input | 32 | Bits to OR into the slot-issue vector |
| cmd_we | input | 1 | Command-register write strobe; requests a scan |
| eng_bsy | input | 1 | Engine busy status bit |
| eng_drq | input | 1 | Engine data-request status bit |
| disp_ack | input | 1 | Engine has handled the offered slot |
| disp_valid | output | 1 | A slot is being offered |
| disp_slot | output | 5 | Binary index of the offered slot |
| issue_vec | output | 32 | Current slot-issue vector |

## Verification
The hardest situation to reach is the hand-off between a slot left running and the pass that follows it. The engine must acknowledge with its busy bit raised. The pass must then end on the busy engine, and only a later drop of both status bits may clear the held slot and start the next offer. The bench holds `eng_bsy` or `eng_drq` across the acknowledge edge and checks that the bit survives while busy. It then checks that the next offer is the following slot and appears only after the status falls. A second directed case raises a port reset between the busy acknowledge and the idle drop, to show that the orphaned bit is left alone.

// File: rtl/slotscan_pkg.sv
package slotscan_pkg;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SCAN  = 2'd1,
        SC_OFFER = 2'd2
    } scan_state_e;

    // Engine cannot take a new command while either status bit is up.
    function automatic logic engine_busy(input logic bsy, input logic drq);
        return bsy | drq;
    endfunction

endpackage

// File: rtl/issue_reg.sv
module issue_reg #(
    parameter int unsigned NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we,
    input  logic [NSLOT-1:0] set_data,
    input  logic [NSLOT-1:0] clr_mask,
    output logic [NSLOT-1:0] vec
);
    // Clears are applied first, so a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (rst) vec <= '0;
        else     vec <= (vec & ~clr_mask) | (set_we ? set_data : '0);
    end

    // R2 / R5: the vector changes only through a write or a clear
    assert_vec_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!set_we && clr_mask == '0) |=> $stable(vec));
endmodule

// File: rtl/slot_picker.sv
module slot_picker #(
    parameter int unsigned NSLOT = 32,
    parameter int unsigned IW    = 5
) (
    input  logic [NSLOT-1:0] req,
    input  logic [IW:0]      from,
    output logic             found,
    output logic [IW-1:0]    idx
);
    localparam int unsigned CW = IW + 1;

    logic [NSLOT-1:0] cand;

    for (genvar i = 0; i < NSLOT; i++) begin : g_cand
        assign cand[i] = req[i] && (CW'(i) >= from);
    end

    // Lowest candidate wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/busy_tracker.sv
module busy_tracker #(
    parameter int unsigned NSLOT = 32,
    parameter int unsigned IW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_rst,
    input  logic             rec_en,
    input  logic [IW-1:0]    rec_slot,
    input  logic             eng_busy,
    output logic             held,
    output logic [IW-1:0]    held_slot,
    output logic             retire,
    output logic [NSLOT-1:0] held_mask
);
    assign held_mask = held ? (NSLOT'(1) << held_slot) : '0;
    assign retire    = held && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst || port_rst) begin
            held      <= 1'b0;
            held_slot <= '0;
        end else if (rec_en) begin
            held      <= 1'b1;
            held_slot <= rec_slot;
        end else if (retire) begin
            held      <= 1'b0;
        end
    end

    // R10: a port reset always empties the record
    assert_portrst_drop_R10: assert property (@(posedge clk) disable iff (rst)
        port_rst |=> !held);
endmodule

// File: rtl/cmd_slot_scanner.sv
module cmd_slot_scanner
    import slotscan_pkg::*;
#(
    parameter int unsigned NSLOT = 32,
    localparam int unsigned IW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_rst,
    input  logic             run_en,
    input  logic             issue_we,
    input  logic [NSLOT-1:0] issue_wdata,
    input  logic             cmd_we,
    input  logic             eng_bsy,
    input  logic             eng_drq,
    input  logic             disp_ack,
    output logic             disp_valid,
    output logic [IW-1:0]    disp_slot,
    output logic [NSLOT-1:0] issue_vec
);
    localparam int unsigned CW = IW + 1;

    scan_state_e      state;
    logic             scan_req;
    logic [CW-1:0]    cursor;
    logic [IW-1:0]    cur_slot;
    logic             busy;
    logic             ack_go;
    logic             rec_en;
    logic             held;
    logic [IW-1:0]    held_slot;
    logic             retire;
    logic [NSLOT-1:0] held_mask;
    logic [NSLOT-1:0] clr_mask;
    logic [NSLOT-1:0] search;
    logic             pick_found;
    logic [IW-1:0]    pick_idx;

    assign busy       = engine_busy(eng_bsy, eng_drq);
    assign disp_valid = (state == SC_OFFER);
    assign disp_slot  = cur_slot;
    assign ack_go     = disp_valid && disp_ack;
    assign rec_en     = ack_go && busy;
    assign clr_mask   = ((ack_go && !busy) ? (NSLOT'(1) << cur_slot) : '0)
                      | (retire ? held_mask : '0);
    // The held slot is never offered again while it is running.
    assign search     = issue_vec & ~held_mask;

    issue_reg #(.NSLOT(NSLOT)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .set_we   (issue_we),
        .set_data (issue_wdata),
        .clr_mask (clr_mask),
        .vec      (issue_vec)
    );

    slot_picker #(.NSLOT(NSLOT), .IW(IW)) u_pick (
        .req   (search),
        .from  (cursor),
        .found (pick_found),
        .idx   (pick_idx)
    );

    busy_tracker #(.NSLOT(NSLOT), .IW(IW)) u_busy (
        .clk       (clk),
        .rst       (rst),
        .port_rst  (port_rst),
        .rec_en    (rec_en),
        .rec_slot  (cur_slot),
        .eng_busy  (busy),
        .held      (held),
        .held_slot (held_slot),
        .retire    (retire),
        .held_mask (held_mask)
    );

    always_ff @(posedge clk) begin
        if (rst || port_rst) begin
            state    <= SC_IDLE;
            scan_req <= 1'b0;
            cursor   <= '0;
            cur_slot <= '0;
        end else begin
            if (issue_we || cmd_we || retire) scan_req <= 1'b1;
            else if (state == SC_IDLE)        scan_req <= 1'b0;

            unique case (state)
                SC_IDLE: begin
                    if (scan_req && run_en && (issue_vec != '0)) begin
                        state  <= SC_SCAN;
                        cursor <= '0;
                    end
                end
                SC_SCAN: begin
                    if (busy || !pick_found) begin
                        state <= SC_IDLE;
                    end else begin
                        state    <= SC_OFFER;
                        cur_slot <= pick_idx;
                    end
                end
                SC_OFFER: begin
                    if (disp_ack) begin
                        if (cur_slot == IW'(NSLOT - 1)) begin
                            state <= SC_IDLE;
                        end else begin
                            state  <= SC_SCAN;
                            cursor <= CW'(cur_slot) + CW'(1);
                        end
                    end else if (busy) begin
                        state <= SC_IDLE;
                    end
                end
                default: state <= SC_IDLE;
            endcase
        end
    end

    // R4: only issued slots are offered
    assert_offer_issued_R4: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> issue_vec[disp_slot]);

    // R4: an idle engine sees a steady offer until it acknowledges
    assert_offer_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ack && !busy && !port_rst)
            |=> (disp_valid && $stable(disp_slot)));

    // R5: synchronous completion retires the slot bit
    assert_sync_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_go && !busy && !issue_we) |=> !issue_vec[$past(disp_slot)]);

    // R6: an offer never starts against a busy engine
    assert_no_offer_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_valid) |-> !$past(busy));

    // R6: an unacknowledged offer is withdrawn once the engine is busy
    assert_withdraw_R6: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ack && busy) |=> !disp_valid);

    // R7: a slot acknowledged while busy stays issued and is recorded
    assert_busy_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_go && busy && !port_rst) |=> (issue_vec[$past(disp_slot)] && held));

    // R8: the recorded slot is cleared once the engine goes idle
    assert_retire_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (retire && !issue_we && !port_rst) |=> !issue_vec[$past(held_slot)]);

    // R10: a port reset withdraws any offer
    assert_portrst_idle_R10: assert property (@(posedge clk) disable iff (rst)
        port_rst |=> !disp_valid);
endmodule

// File: tb/sim_cmd_slot_scanner.sv
module sim_cmd_slot_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             port_rst = 1'b0;
    logic             run_en = 1'b0;
    logic             issue_we = 1'b0;
    logic [NSLOT-1:0] issue_wdata = '0;
    logic             cmd_we = 1'b0;
    logic             eng_bsy = 1'b0;
    logic             eng_drq = 1'b0;
    logic             disp_ack = 1'b0;
    logic             disp_valid;
    logic [4:0]       disp_slot;
    logic [NSLOT-1:0] issue_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmd_slot_scanner #(.NSLOT(NSLOT)) u0 (
        .clk(clk), .rst(rst), .port_rst(port_rst), .run_en(run_en),
        .issue_we(issue_we), .issue_wdata(issue_wdata), .cmd_we(cmd_we),
        .eng_bsy(eng_bsy), .eng_drq(eng_drq), .disp_ack(disp_ack),
        .disp_valid(disp_valid), .disp_slot(disp_slot), .issue_vec(issue_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected vector after ORing a write into the model value.
    function automatic logic [31:0] or_in(input logic [31:0] cur, input logic [31:0] w);
        return cur | w;
    endfunction

    task automatic write_issue(input logic [31:0] v);
        issue_we = 1'b1; issue_wdata = v;
        @(negedge clk);
        issue_we = 1'b0; issue_wdata = '0;
    endtask

    task automatic write_cmd();
        cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic idle_check(input string req, input int n, input logic [31:0] exp_vec);
        logic seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (disp_valid) seen = 1'b1;
        end
        chk(req, {31'd0, seen}, 32'd0);
        chk(req, issue_vec, exp_vec);
    endtask

    // Wait for an offer, check the slot, hold it a random time, then ack.
    task automatic serve(input int exp, input logic stuck, input string req);
        int n = 0;
        int dly;
        logic steady = 1'b1;
        while (!disp_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, disp_valid}, 32'd1);
        chk(req, {27'd0, disp_slot}, exp);
        dly = int'($urandom % 3);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            if (!disp_valid || disp_slot != exp[4:0]) steady = 1'b0;
        end
        if (dly > 0) chk("R4 hold", {31'd0, steady}, 32'd1);
        disp_ack = 1'b1;
        eng_bsy  = stuck;
        @(negedge clk);
        disp_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] model;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'd0, disp_valid}, 32'd0);
        chk("R1 vec", issue_vec, 32'd0);

        // R2 / R3: writes accumulate, nothing offered while stopped
        write_issue(32'h0000_0005);
        write_issue(32'h0000_0030);
        model = or_in(32'h5, 32'h30);
        idle_check("R3 stopped", 10, model);
        chk("R2 or", issue_vec, 32'h35);

        // R9: command write with start set launches the pass, R4 order, R5 clear
        run_en = 1'b1;
        write_cmd();
        serve(0, 1'b0, "R9 first");
        serve(2, 1'b0, "R4 order");
        serve(4, 1'b0, "R4 order");
        serve(5, 1'b0, "R4 order");
        idle_check("R5 cleared", 4, 32'd0);

        // R6: busy engine is never offered; request is dropped
        eng_bsy = 1'b1;
        write_issue(32'h0000_0003);
        idle_check("R6 busy", 10, 32'h3);
        eng_bsy = 1'b0;
        idle_check("R3 dropped", 5, 32'h3);
        write_cmd();
        serve(0, 1'b0, "R6 resume");
        serve(1, 1'b0, "R6 resume");
        idle_check("R6 done", 4, 32'd0);

        // R6: offer withdrawn when data-request rises without ack
        write_issue(32'h0000_0001);
        while (!disp_valid) @(negedge clk);
        eng_drq = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 withdraw", {31'd0, disp_valid}, 32'd0);
        chk("R6 kept", issue_vec, 32'h1);
        eng_drq = 1'b0;
        write_cmd();
        serve(0, 1'b0, "R6 retry");
        idle_check("R6 retry", 4, 32'd0);

        // R7 / R8: slot left busy, retired when status drops
        write_issue(32'h0000_000C);
        serve(2, 1'b1, "R7 busy ack");
        idle_check("R7 kept", 4, 32'h0000_000C);
        eng_bsy = 1'b0;
        serve(3, 1'b0, "R8 rescan");
        chk("R8 retired", issue_vec, 32'd0);
        idle_check("R8 done", 4, 32'd0);

        // R10: port reset drops the record, bit is orphaned
        write_issue(32'h0000_0010);
        serve(4, 1'b0, "R10 setup");
        write_issue(32'h0000_0010);
        while (!disp_valid) @(negedge clk);
        disp_ack = 1'b1; eng_drq = 1'b1;
        @(negedge clk);
        disp_ack = 1'b0;
        port_rst = 1'b1;
        @(negedge clk);
        port_rst = 1'b0;
        eng_drq  = 1'b0;
        idle_check("R10 orphan", 6, 32'h10);
        write_cmd();
        serve(4, 1'b0, "R10 rescan");
        idle_check("R10 clean", 4, 32'd0);

        // R10: port reset withdraws a live offer and cancels the pass
        write_issue(32'h0000_0140);
        while (!disp_valid) @(negedge clk);
        chk("R10 offer", {27'd0, disp_slot}, 32'd6);
        port_rst = 1'b1;
        @(negedge clk);
        port_rst = 1'b0;
        chk("R10 withdraw", {31'd0, disp_valid}, 32'd0);
        idle_check("R10 cancel", 6, 32'h140);
        write_cmd();
        serve(6, 1'b0, "R10 again");
        serve(8, 1'b0, "R10 again");
        idle_check("R10 end", 4, 32'd0);

        // R4 / R5 random vectors, engine always finishes synchronously
        for (int it = 0; it < 40; it++) begin
            logic [31:0] v;
            v = $urandom;
            if (it == 0) v = 32'h8000_0001;
            if (it == 1) v = 32'hFFFF_FFFF;
            write_issue(v);
            for (int s = 0; s < NSLOT; s++) begin
                if (v[s]) serve(s, 1'b0, "R4 random");
            end
            idle_check("R5 random", 4, 32'd0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule